// File: doc/BRIEF.md
# Four-Lane 32-Bit Permute Unit

This block rearranges the 32-bit lanes of two 128-bit operands, `in_a` and `in_b`. Each operand holds four lanes, and lane 0 sits in bits [31:0]. An opcode picks one of eight data movements:

- selecting shuffle
- low interleave
- high interleave
- mask blend
- low-word replace
- high-to-low half move
- low-to-high half move
- sign-mask gather

Some operations are steered by an 8-bit immediate. Lanes are moved as raw bits: no arithmetic is done on their contents.

A request is a single cycle with `in_valid` high. The routed vector is captured in an output register. `out_valid` then pulses for one cycle. The result holds its value until the next request.

Top module: `lane_perm_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid` is 0 and `out_result` is all zero.
- R2: A request sampled at a rising edge makes `out_valid` high for exactly that following cycle. Without a request, `out_valid` is 0 and `out_result` keeps its value.
- R3: Opcode 4'h0 (shuffle) splits the immediate into 2-bit indices: i = imm[1:0], j = imm[3:2], k = imm[5:4], l = imm[7:6]. The result lanes 0..3 are A[i], A[j], B[k], B[l].
- R4: Opcode 4'h1 (low interleave) gives lanes 0..3 = A0, B0, A1, B1.
- R5: Opcode 4'h2 (high interleave) gives lanes 0..3 = A2, B2, A3, B3.
- R6: Opcode 4'h3 (blend) sets result lane n to B's lane n when imm[n] is 1 and to A's lane n when imm[n] is 0. imm[7:4] is ignored.
- R7: Opcode 4'h4 (low-word replace) gives lanes 0..3 = B0, A1, A2, A3.
- R8: Opcode 4'h5 (high-to-low move) gives lanes 0..3 = B2, B3, A2, A3.
- R9: Opcode 4'h6 (low-to-high move) gives lanes 0..3 = A0, A1, B0, B1.
- R10: Opcode 4'h7 (sign gather) places bit 31 of A's lane n at result bit n. Result bits [127:4] are zero.
- R11: Opcodes 4'h8 to 4'hF give an all-zero result, and `out_valid` still pulses.
- R12: The immediate has no effect on opcodes other than shuffle and blend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Operation code |
| in_imm | input | 8 | Immediate (indices or blend mask) |
| in_a | input | 128 | First operand, lane 0 in bits [31:0] |
| in_b | input | 128 | Second operand |
| out_valid | output | 1 | One-cycle pulse per request |
| out_result | output | 128 | Registered result |

## Verification
The operands use distinct lane words, and their sign bits differ from lane to lane. Any wrong lane source, swapped half or misplaced mask bit therefore shows up as a different word.

Shuffle is run with three index patterns:
- identity
- full reversal
- all-zero broadcast

These tell apart the correct index field per lane from a shared or reordered field. Blend is run with an empty mask, a full mask, a single-lane mask and an alternating mask with junk in the upper nibble.

Back-to-back requests, idle cycles with changing inputs, an unsupported code and a reset in mid-run check the register timing and the hold behaviour.

// File: rtl/lane_perm_pkg.sv
package lane_perm_pkg;
    localparam int LANE_W = 32;
    localparam int LANES  = 4;
    localparam int HALF   = LANES / 2;
    localparam int IDX_W  = $clog2(LANES);
    localparam int IMM_W  = LANES * IDX_W;
    localparam int VEC_W  = LANE_W * LANES;
    localparam int OP_W   = 4;

    typedef logic [LANE_W-1:0] lane_t;
    typedef lane_t [LANES-1:0] vec_t;

    typedef enum logic [OP_W-1:0] {
        OP_SHUF  = 4'h0,
        OP_ILO   = 4'h1,
        OP_IHI   = 4'h2,
        OP_BLEND = 4'h3,
        OP_MOVLW = 4'h4,
        OP_MOVHL = 4'h5,
        OP_MOVLH = 4'h6,
        OP_SMASK = 4'h7
    } perm_op_e;

    function automatic logic [LANES-1:0] gather_signs(input vec_t v);
        logic [LANES-1:0] m;
        for (int n = 0; n < LANES; n++) begin
            m[n] = v[n][LANE_W-1];
        end
        return m;
    endfunction
endpackage

// File: rtl/perm_route.sv
module perm_route
    import lane_perm_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  logic [IMM_W-1:0] imm,
    input  vec_t             a,
    input  vec_t             b,
    output vec_t             res
);
    logic [LANES-1:0] signs;

    always_comb begin
        signs = gather_signs(a);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [IDX_W-1:0] sel;
        lane_t shuf_l, ilo_l, ihi_l, blend_l, mlw_l, mhl_l, mlh_l, mask_l;

        always_comb begin
            sel     = imm[g*IDX_W +: IDX_W];
            shuf_l  = (g < HALF) ? a[sel] : b[sel];
            ilo_l   = (g % 2 == 0) ? a[g/2] : b[g/2];
            ihi_l   = (g % 2 == 0) ? a[HALF + g/2] : b[HALF + g/2];
            blend_l = imm[g] ? b[g] : a[g];
            mlw_l   = (g == 0) ? b[g] : a[g];
            mhl_l   = (g < HALF) ? b[(g + HALF) % LANES] : a[g];
            mlh_l   = (g < HALF) ? a[g] : b[(g + HALF) % LANES];
            mask_l  = (g == 0) ? lane_t'(signs) : '0;
        end

        always_comb begin
            case (op)
                OP_SHUF:  res[g] = shuf_l;
                OP_ILO:   res[g] = ilo_l;
                OP_IHI:   res[g] = ihi_l;
                OP_BLEND: res[g] = blend_l;
                OP_MOVLW: res[g] = mlw_l;
                OP_MOVHL: res[g] = mhl_l;
                OP_MOVLH: res[g] = mlh_l;
                OP_SMASK: res[g] = mask_l;
                default:  res[g] = '0;
            endcase
        end
    end
endmodule

// File: rtl/perm_stage.sv
module perm_stage #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] d,
    output logic         q_valid,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q       <= '0;
        end else begin
            q_valid <= in_valid;
            if (in_valid) begin
                q <= d;
            end
        end
    end
endmodule

// File: rtl/lane_perm_unit.sv
module lane_perm_unit
    import lane_perm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  in_op,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [VEC_W-1:0] in_a,
    input  logic [VEC_W-1:0] in_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_result
);
    vec_t va, vb, routed;

    always_comb begin
        va = in_a;
        vb = in_b;
    end

    perm_route u_route (
        .op  (in_op),
        .imm (in_imm),
        .a   (va),
        .b   (vb),
        .res (routed)
    );

    perm_stage #(.W(VEC_W)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .d        (routed),
        .q_valid  (out_valid),
        .q        (out_result)
    );
endmodule

// File: rtl/perm_checks.sv
module perm_checks
    import lane_perm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [OP_W-1:0]  in_op,
    input logic [VEC_W-1:0] in_a,
    input logic [VEC_W-1:0] in_b,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_result
);
    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0));
    assert_bad_op_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[3]) |=> (out_result == '0));
    assert_mask_upper_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_SMASK) |=> (out_result[VEC_W-1:LANES] == '0));
    assert_mask_bits_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_SMASK) |=>
        (out_result[3:0] == {$past(in_a[127]), $past(in_a[95]), $past(in_a[63]), $past(in_a[31])}));
    assert_lowword_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_MOVLW) |=>
        (out_result[31:0] == $past(in_b[31:0]) && out_result[127:32] == $past(in_a[127:32])));
endmodule

bind lane_perm_unit perm_checks u_checks (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/lane_perm_unit_test.sv
`timescale 1ns/1ps
module lane_perm_unit_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [3:0]   in_op = 4'h0;
    logic [7:0]   in_imm = 8'h00;
    logic [127:0] in_a = '0;
    logic [127:0] in_b = '0;
    logic         out_valid;
    logic [127:0] out_result;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lane_perm_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_imm(in_imm), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_result(out_result)
    );

    localparam logic [31:0] A0 = 32'h1111_0000, A1 = 32'h9111_0001;
    localparam logic [31:0] A2 = 32'h2111_0002, A3 = 32'hA111_0003;
    localparam logic [31:0] B0 = 32'hB222_0000, B1 = 32'h3222_0001;
    localparam logic [31:0] B2 = 32'hC222_0002, B3 = 32'hD222_0003;
    localparam logic [127:0] AV = {A3, A2, A1, A0};
    localparam logic [127:0] BV = {B3, B2, B1, B0};

    typedef struct packed {
        logic [3:0]   op;
        logic [7:0]   imm;
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VT [0:NV-1] = '{
        '{4'h0, 8'hE4, AV, BV, {B3, B2, A1, A0}},   // R3 identity indices
        '{4'h0, 8'h1B, AV, BV, {B0, B1, A2, A3}},   // R3 reversed indices
        '{4'h0, 8'h00, AV, BV, {B0, B0, A0, A0}},   // R3 broadcast
        '{4'h1, 8'h00, AV, BV, {B1, A1, B0, A0}},   // R4
        '{4'h2, 8'h00, AV, BV, {B3, A3, B2, A2}},   // R5
        '{4'h3, 8'h02, AV, BV, {A3, A2, B1, A0}},   // R6 single lane
        '{4'h3, 8'hF5, AV, BV, {A3, B2, A1, B0}},   // R6 upper nibble ignored
        '{4'h3, 8'h0F, AV, BV, BV},                 // R6 full mask
        '{4'h3, 8'h00, AV, BV, AV},                 // R6 empty mask
        '{4'h4, 8'h00, AV, BV, {A3, A2, A1, B0}},   // R7
        '{4'h5, 8'h00, AV, BV, {A3, A2, B3, B2}},   // R8
        '{4'h6, 8'h00, AV, BV, {B1, B0, A1, A0}},   // R9
        '{4'h7, 8'h00, AV, BV, {124'd0, 4'b1010}},  // R10
        '{4'h7, 8'h00, BV, AV, {124'd0, 4'b1101}},  // R10 other signs
        '{4'hB, 8'hFF, AV, BV, 128'd0},             // R11
        '{4'h1, 8'hFF, AV, BV, {B1, A1, B0, A0}},   // R12 imm on interleave
        '{4'h4, 8'hFF, AV, BV, {A3, A2, A1, B0}}    // R12 imm on low-word
    };
    localparam int TAG [0:NV-1] = '{3, 3, 3, 4, 5, 6, 6, 6, 6, 7, 8, 9, 10, 10, 11, 12, 12};

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [7:0] imm,
                         input logic [127:0] a, input logic [127:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_imm = imm; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [127:0] held;
        @(negedge clk);
        check("R1 valid in reset", {127'd0, out_valid}, 128'd0);
        check("R1 result in reset", out_result, 128'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", {127'd0, out_valid}, 128'd0);
        check("R1 result after reset", out_result, 128'd0);

        for (int n = 0; n < NV; n++) begin
            issue(VT[n].op, VT[n].imm, VT[n].a, VT[n].b);
            check($sformatf("R%0d vector %0d", TAG[n], n), out_result, VT[n].exp);
            check($sformatf("R2 valid pulse vector %0d", n), {127'd0, out_valid}, 128'd1);
            in_a = ~in_a; in_b = ~in_b; in_op = 4'h2;
            @(negedge clk);
            check("R2 valid drops", {127'd0, out_valid}, 128'd0);
            check("R2 result held", out_result, VT[n].exp);
        end

        // R2 back-to-back requests
        @(negedge clk);
        in_valid = 1'b1; in_op = 4'h1; in_imm = 8'h00; in_a = AV; in_b = BV;
        @(negedge clk);
        check("R2 first of pair", out_result, {B1, A1, B0, A0});
        in_op = 4'h2;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 second of pair", out_result, {B3, A3, B2, A2});
        check("R2 valid on second", {127'd0, out_valid}, 128'd1);
        @(negedge clk);
        check("R2 valid after pair", {127'd0, out_valid}, 128'd0);

        // R2 long idle with changing inputs
        held = out_result;
        for (int k = 0; k < 5; k++) begin
            in_a = {4{32'h0 + k}}; in_op = 4'(k);
            @(negedge clk);
        end
        check("R2 idle hold", out_result, held);

        // R1 reset mid-run
        issue(4'h3, 8'h0F, AV, BV);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-run reset result", out_result, 128'd0);
        check("R1 mid-run reset valid", {127'd0, out_valid}, 128'd0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule